// File: doc/BRIEF.md
# Center-Aligned PWM Channel with Shadowed Compare

This block generates one symmetric (center-aligned) pulse-width-modulated output. A counter ramps from zero up to a programmable period and back down to zero, so each switching cycle spans twice the period in counter ticks. For a wanted switching frequency, the period is the counter clock divided by twice that frequency. For example, a 100 MHz clock and a 16 kHz target give a period of 3125.

The duty level is set through a compare value. Writes go into a holding register, and the compare that is used moves to that value only when the counter sits at zero. This means a new duty never lands partway through a cycle. The output goes low on the compare match while counting up and goes high on the match while counting down, so the high time is centred on the counter zero.

Two compare values are treated as explicit end points. Zero gives a fully low cycle, even when it is loaded at the same instant that the counter is zero. A value at or above the period gives a fully high cycle. A phase input lets a follower channel jump to a chosen count when a sync pulse arrives. Loading the period as the phase gives a half-cycle (180 degree) offset. The block itself emits a pulse at counter zero for followers, and a pulse at the counter peak for a once-per-cycle event.

Top module: `cpwm_channel`

## Requirements
- R1: While `rst_ni` is low, `cnt_o` is 0, `dir_o` is 1 (counting up), `pwm_o` is 0, and the holding and used compare values are 0.
- R2: With `en_i` high and period P ≥ 1, `cnt_o` steps by one per clock through 0,1,…,P,P-1,…,1,0 and repeats. `dir_o` is 0 (down) on the clock where `cnt_o` equals P and 1 (up) where it equals 0.
- R3: A write through `cmp_we_i` changes only the holding register. The compare that is used takes the holding value only on a clock where `cnt_o` is 0, and that value governs the whole cycle that starts there.
- R4: For 0 < C < P, `pwm_o` drops to 0 on the clock after `cnt_o` equals C while counting up, and rises to 1 on the clock after `cnt_o` equals C while counting down. This gives 2·C high clocks per 2·P-clock cycle.
- R5: A compare value of 0 gives `pwm_o` = 0 from the clock after the zero-count load through the whole cycle. This includes the case where the previous cycle ended high, and the output never stays high for a full cycle.
- R6: A compare value ≥ P (P ≥ 1) keeps `pwm_o` at 1 for the whole cycle.
- R7: When `sync_i` and `phase_en_i` are both high, the next `cnt_o` is `phase_i`, clamped to P. `dir_o` becomes 0 if the loaded value equals P, and 1 otherwise. When `phase_en_i` is low, `sync_i` has no effect on the count.
- R8: `sync_o` is high exactly on clocks where `en_i` is high and `cnt_o` is 0. `peak_o` is high exactly on clocks where `en_i` is high and `cnt_o` equals P ≥ 1. Each is high once per 2·P-clock cycle.
- R9: While `en_i` is low, `cnt_o`, `dir_o` and `pwm_o` hold their values and both event pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low freezes the channel |
| period_i | input | CNT_W | Peak count P |
| cmp_wdata_i | input | CNT_W | Compare value to store in the holding register |
| cmp_we_i | input | 1 | Write strobe for `cmp_wdata_i` |
| phase_i | input | CNT_W | Count to load on a sync pulse |
| phase_en_i | input | 1 | Allows `sync_i` to load `phase_i` |
| sync_i | input | 1 | Sync pulse from a leading channel |
| pwm_o | output | 1 | PWM level |
| cnt_o | output | CNT_W | Current count |
| dir_o | output | 1 | 1 = counting up, 0 = counting down |
| sync_o | output | 1 | Pulse at count zero |
| peak_o | output | 1 | Pulse at count equal to period |

## Verification
The hardest case to reach is the contention case: a zero compare becomes active at the counter's zero instant, right after a cycle that ended with the output high. Random stimulus rarely lines up a write with that window. The bench therefore first runs the channel at a mid duty, then writes zero while the counter is on its way down, so that the load happens at the very next zero. It then counts high samples across the cycle that follows. A second directed case writes a new value mid-cycle and watches the down-count match point, which shows that the old compare is still in use until the zero load.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;
   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } cpwm_dir_e;

   localparam int unsigned CPWM_MIN_W = 2;
   localparam int unsigned CPWM_MAX_W = 32;
endpackage

// File: rtl/cpwm_timebase.sv
`timescale 1ns/1ps
module cpwm_timebase
   import cpwm_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] phase_i,
   input  logic             phase_en_i,
   input  logic             sync_i,
   output logic [CNT_W-1:0] cnt_o,
   output cpwm_dir_e        dir_o,
   output logic             at_zero_o,
   output logic             at_peak_o
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] cnt_q, cnt_d;
   cpwm_dir_e        dir_q, dir_d;
   logic             period_zero;
   logic             load_phase;

   assign period_zero = (period_i == ZERO);
   assign load_phase  = sync_i && phase_en_i;

   always_comb begin
      cnt_d = cnt_q;
      dir_d = dir_q;
      if (load_phase) begin
         if (period_zero) begin
            cnt_d = ZERO;
            dir_d = DIR_UP;
         end else if (phase_i >= period_i) begin
            cnt_d = period_i;
            dir_d = DIR_DOWN;
         end else begin
            cnt_d = phase_i;
            dir_d = DIR_UP;
         end
      end else if (period_zero) begin
         cnt_d = ZERO;
         dir_d = DIR_UP;
      end else if (dir_q == DIR_UP) begin
         if (cnt_q >= period_i - ONE) begin
            cnt_d = period_i;
            dir_d = DIR_DOWN;
         end else begin
            cnt_d = cnt_q + ONE;
         end
      end else begin
         if (cnt_q <= ONE) begin
            cnt_d = ZERO;
            dir_d = DIR_UP;
         end else begin
            cnt_d = cnt_q - ONE;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= ZERO;
         dir_q <= DIR_UP;
      end else if (en_i) begin
         cnt_q <= cnt_d;
         dir_q <= dir_d;
      end
   end

   assign cnt_o     = cnt_q;
   assign dir_o     = dir_q;
   assign at_zero_o = (cnt_q == ZERO);
   assign at_peak_o = (cnt_q == period_i) && !period_zero;
endmodule

// File: rtl/cpwm_cmp_hold.sv
`timescale 1ns/1ps
module cpwm_cmp_hold #(
   parameter int unsigned CNT_W     = 16,
   parameter bit          SHADOW_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             at_zero_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic             we_i,
   output logic [CNT_W-1:0] cmp_act_o,
   output logic [CNT_W-1:0] cmp_eff_o
);
   logic [CNT_W-1:0] act_q;

   generate
      if (SHADOW_EN) begin : g_shadow
         logic [CNT_W-1:0] hold_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               hold_q <= '0;
            end else if (we_i) begin
               hold_q <= wdata_i;
            end
         end
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               act_q <= '0;
            end else if (en_i && at_zero_i) begin
               act_q <= hold_q;
            end
         end
         // the value taken at zero already decides the zero clock itself
         assign cmp_eff_o = at_zero_i ? hold_q : act_q;
      end else begin : g_direct
         logic unused_ok;
         assign unused_ok = en_i ^ at_zero_i;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               act_q <= '0;
            end else if (we_i) begin
               act_q <= wdata_i;
            end
         end
         assign cmp_eff_o = act_q;
      end
   endgenerate

   assign cmp_act_o = act_q;
endmodule

// File: rtl/cpwm_action.sv
`timescale 1ns/1ps
module cpwm_action
   import cpwm_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  cpwm_dir_e        dir_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] cmp_i,
   output logic             pwm_o
);
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_CLEAR = 2'd1,
      ACT_SET   = 2'd2
   } act_e;

   act_e act;
   logic pwm_q;

   always_comb begin
      act = ACT_HOLD;
      if (cmp_i == '0) begin
         act = ACT_CLEAR;
      end else if (cmp_i >= period_i) begin
         act = ACT_SET;
      end else if (cnt_i == cmp_i) begin
         act = (dir_i == DIR_UP) ? ACT_CLEAR : ACT_SET;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pwm_q <= 1'b0;
      end else if (en_i) begin
         unique case (act)
            ACT_CLEAR: pwm_q <= 1'b0;
            ACT_SET:   pwm_q <= 1'b1;
            default:   pwm_q <= pwm_q;
         endcase
      end
   end

   assign pwm_o = pwm_q;
endmodule

// File: rtl/cpwm_channel.sv
`timescale 1ns/1ps
module cpwm_channel
   import cpwm_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter bit          SHADOW_EN = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] cmp_wdata_i,
   input  logic             cmp_we_i,
   input  logic [CNT_W-1:0] phase_i,
   input  logic             phase_en_i,
   input  logic             sync_i,
   output logic             pwm_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             dir_o,
   output logic             sync_o,
   output logic             peak_o
);
   generate
      if (CNT_W < CPWM_MIN_W || CNT_W > CPWM_MAX_W) begin : g_bad_width
         $error("cpwm_channel: CNT_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   cpwm_dir_e        dir;
   logic             at_zero;
   logic             at_peak;
   logic [CNT_W-1:0] cmp_act;
   logic [CNT_W-1:0] cmp_eff;

   cpwm_timebase #(.CNT_W(CNT_W)) u_tb (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_i),
      .period_i   (period_i),
      .phase_i    (phase_i),
      .phase_en_i (phase_en_i),
      .sync_i     (sync_i),
      .cnt_o      (cnt),
      .dir_o      (dir),
      .at_zero_o  (at_zero),
      .at_peak_o  (at_peak)
   );

   cpwm_cmp_hold #(.CNT_W(CNT_W), .SHADOW_EN(SHADOW_EN)) u_cmp (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .at_zero_i (at_zero),
      .wdata_i   (cmp_wdata_i),
      .we_i      (cmp_we_i),
      .cmp_act_o (cmp_act),
      .cmp_eff_o (cmp_eff)
   );

   cpwm_action #(.CNT_W(CNT_W)) u_act (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .cnt_i    (cnt),
      .dir_i    (dir),
      .period_i (period_i),
      .cmp_i    (cmp_eff),
      .pwm_o    (pwm_o)
   );

   assign cnt_o  = cnt;
   assign dir_o  = dir;
   assign sync_o = en_i && at_zero;
   assign peak_o = en_i && at_peak;
endmodule

// File: rtl/cpwm_channel_chk.sv
`timescale 1ns/1ps
module cpwm_channel_chk #(
   parameter int unsigned CNT_W     = 16,
   parameter bit          SHADOW_EN = 1'b1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             en_i,
   input logic [CNT_W-1:0] period_i,
   input logic [CNT_W-1:0] phase_i,
   input logic             phase_en_i,
   input logic             sync_i,
   input logic             pwm_o,
   input logic [CNT_W-1:0] cnt_o,
   input logic             dir_o,
   input logic             sync_o,
   input logic             peak_o,
   input logic [CNT_W-1:0] cmp_act,
   input logic [CNT_W-1:0] cmp_eff
);
   p_dir_down_at_peak_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($stable(period_i) && period_i != '0 && cnt_o == period_i) |-> !dir_o);

   p_dir_up_at_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_o == '0) |-> dir_o);

   p_unit_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !(sync_i && phase_en_i) && cnt_o != '0 && cnt_o < period_i)
      |=> (cnt_o == $past(cnt_o) + 1'b1) || (cnt_o == $past(cnt_o) - 1'b1));

   generate
      if (SHADOW_EN) begin : g_hold_chk
         p_act_only_at_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!en_i || cnt_o != '0) |=> $stable(cmp_act));
      end
   endgenerate

   p_up_match_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && cmp_eff != '0 && cmp_eff < period_i && cnt_o == cmp_eff && dir_o) |=> !pwm_o);

   p_down_match_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && cmp_eff != '0 && cmp_eff < period_i && cnt_o == cmp_eff && !dir_o) |=> pwm_o);

   p_zero_cmp_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && cmp_eff == '0) |=> !pwm_o);

   p_full_cmp_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && cmp_eff != '0 && cmp_eff >= period_i) |=> pwm_o);

   p_phase_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && sync_i && phase_en_i && period_i != '0 && phase_i < period_i)
      |=> (cnt_o == $past(phase_i)) && dir_o);

   p_events_apart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (period_i != '0) |-> $onehot0({sync_o, peak_o}));

   p_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> $stable(cnt_o) && $stable(pwm_o) && $stable(dir_o));
endmodule

bind cpwm_channel cpwm_channel_chk #(.CNT_W(CNT_W), .SHADOW_EN(SHADOW_EN)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .en_i       (en_i),
   .period_i   (period_i),
   .phase_i    (phase_i),
   .phase_en_i (phase_en_i),
   .sync_i     (sync_i),
   .pwm_o      (pwm_o),
   .cnt_o      (cnt_o),
   .dir_o      (dir_o),
   .sync_o     (sync_o),
   .peak_o     (peak_o),
   .cmp_act    (cmp_act),
   .cmp_eff    (cmp_eff)
);

// File: tb/cpwm_channel_tb_top.sv
`timescale 1ns/1ps
module cpwm_channel_tb_top;
   localparam int unsigned W = 16;
   localparam int unsigned NV = 8;
   localparam int unsigned VP [NV] = '{10, 10, 10, 10, 10, 10, 6, 6};
   localparam int unsigned VC [NV] = '{ 3,  0, 10, 15,  1,  9, 2, 5};
   localparam int unsigned VH [NV] = '{ 6,  0, 20, 20,  2, 18, 4, 10};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         en = 1'b0;
   logic [W-1:0] period = '0;
   logic [W-1:0] wdata = '0;
   logic         we = 1'b0;
   logic [W-1:0] phase = '0;
   logic         phase_en = 1'b0;
   logic         sync_in = 1'b0;
   logic         pwm;
   logic [W-1:0] cnt;
   logic         dir;
   logic         sync_out;
   logic         peak;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   cpwm_channel #(.CNT_W(W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .period_i(period),
      .cmp_wdata_i(wdata), .cmp_we_i(we), .phase_i(phase),
      .phase_en_i(phase_en), .sync_i(sync_in), .pwm_o(pwm),
      .cnt_o(cnt), .dir_o(dir), .sync_o(sync_out), .peak_o(peak)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_cmp(input int unsigned v);
      wdata = W'(v);
      we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic wait_at(input int unsigned v, input logic d);
      while (!(cnt == W'(v) && dir == d)) @(negedge clk);
   endtask

   task automatic pass_zero();
      wait_at(0, 1'b1);
      @(negedge clk);
   endtask

   initial begin
      #(64'd200000 * 20);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int hi, zs, pk, c0;
      logic d0;
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 cnt", cnt, 0);
      chk("R1 dir", dir, 1);
      chk("R1 pwm", pwm, 0);
      rst_n = 1'b1;
      period = W'(5);
      en = 1'b1;
      // R2: full up-down sequence with P=5
      wait_at(0, 1'b1);
      for (int k = 0; k < 10; k++) begin
         int e;
         e = (k <= 5) ? k : 10 - k;
         chk("R2 count", cnt, e);
         if (k == 5) chk("R2 dir at peak", dir, 0);
         if (k == 0) chk("R2 dir at zero", dir, 1);
         @(negedge clk);
      end
      chk("R1 pwm stays low after reset compare", pwm, 0);

      // table: R4/R5/R6 high time, R8 event counts
      for (int v = 0; v < NV; v++) begin
         period = W'(VP[v]);
         write_cmp(VC[v]);
         pass_zero();
         pass_zero();
         wait_at(0, 1'b1);
         hi = 0; zs = 0; pk = 0;
         for (int k = 0; k < 2 * VP[v]; k++) begin
            hi += int'(pwm);
            zs += int'(sync_out);
            pk += int'(peak);
            @(negedge clk);
         end
         chk($sformatf("R4/R5/R6 high clocks P=%0d C=%0d", VP[v], VC[v]), hi, VH[v]);
         chk("R8 sync_o per cycle", zs, 1);
         chk("R8 peak_o per cycle", pk, 1);
      end

      // R3: mid-cycle write does not move the match point until zero
      period = W'(10);
      write_cmp(3);
      pass_zero();
      pass_zero();
      wait_at(5, 1'b1);
      write_cmp(8);
      wait_at(7, 1'b0);
      chk("R3 old compare still used", pwm, 0);
      pass_zero();
      wait_at(7, 1'b0);
      chk("R3 new compare after zero", pwm, 1);

      // R5: zero loaded at zero right after a high-ending cycle
      write_cmp(5);
      pass_zero();
      pass_zero();
      wait_at(3, 1'b0);
      chk("R5 previous cycle high near zero", pwm, 1);
      write_cmp(0);
      wait_at(0, 1'b1);
      @(negedge clk);
      hi = 0;
      for (int k = 1; k < 20; k++) begin
         hi += int'(pwm);
         @(negedge clk);
      end
      chk("R5 contention cycle high clocks", hi, 0);

      // R7: phase load to period, to mid value, and ignored when disabled
      phase = W'(10);
      phase_en = 1'b1;
      sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
      chk("R7 load period cnt", cnt, 10);
      chk("R7 load period dir", dir, 0);
      phase = W'(4);
      sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
      chk("R7 load mid cnt", cnt, 4);
      chk("R7 load mid dir", dir, 1);
      phase_en = 1'b0;
      phase = W'(9);
      c0 = int'(cnt);
      d0 = dir;
      sync_in = 1'b1;
      @(negedge clk);
      sync_in = 1'b0;
      chk("R7 sync ignored without phase enable", cnt, d0 ? c0 + 1 : c0 - 1);

      // R9: freeze while disabled
      write_cmp(4);
      pass_zero();
      pass_zero();
      wait_at(7, 1'b1);
      en = 1'b0;
      @(negedge clk);
      c0 = int'(cnt);
      d0 = pwm;
      repeat (5) @(negedge clk);
      chk("R9 cnt frozen", cnt, c0);
      chk("R9 pwm frozen", pwm, d0);
      chk("R9 peak_o low", peak, 0);
      en = 1'b1;
      wait_at(0, 1'b1);
      en = 1'b0;
      @(negedge clk);
      chk("R9 sync_o low while disabled", sync_out, 0);
      en = 1'b1;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule